// File: doc/BRIEF.md
# Multi-Line Receive Silo

This block collects received characters from four serial receivers into one shared first-in first-out store of 64 entries. Each receiver offers a character together with its parity-error and break (framing-error) flags through a valid/character/flag port group. The block takes at most one character per clock, lowest line number first. It acknowledges the character it took, and it stamps the stored entry with the line number it came from.

The host sees the oldest entry as one 16-bit word. It removes that entry by pulsing the pop strobe in the cycle the word is read. A receive-done output shows that at least one entry is waiting, and it drives an interrupt when the interrupt enable is high. Characters are taken only while the scan enable is high. A master clear empties the store and discards any pending overrun. If a character arrives while the store is full, the character is consumed and lost. The next entry written afterwards then carries an overrun mark.

Top module: `rx_silo`

## Requirements
- R1: After reset, and in the cycle after a master clear, `rd_word` is 0, `rx_done` is 0, `rx_irq` is 0 and `ovr_pend` is 0.
- R2: A valid read word holds the character in bits 7:0, the source line in bits 9:8, zero in bits 11:10, the parity flag in bit 12, the break flag in bit 13, the overrun mark in bit 14 and a 1 in bit 15.
- R3: While the store is empty, `rd_word` is 0 (bit 15 clear). A pop strobe on an empty store has no effect.
- R4: Entries are read in arrival order. A pop at a clock edge makes the next entry visible on `rd_word` right after that edge.
- R5: `rx_done` is 1 exactly when the store holds an entry. `rx_irq` equals `rx_done` while `rx_int_en` is 1 and is 0 otherwise.
- R6: While `scan_en` is 0 or `clr` is 1, no `ln_ack` bit rises and nothing is stored.
- R7: When several lines are valid in one cycle, only the lowest-numbered one is acknowledged and stored in that cycle. The others keep their characters until they are acknowledged.
- R8: The store holds 64 entries. A character offered while it is full is acknowledged but not stored.
- R9: After a character is lost to a full store, `ovr_pend` is 1. The next entry written has bit 14 set, which clears `ovr_pend`. Later entries have bit 14 clear.
- R10: A master clear empties the store and clears a pending overrun, so the next entry written has bit 14 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Master clear, synchronous, active high |
| scan_en | input | 1 | Allows characters to be taken |
| rx_int_en | input | 1 | Receive interrupt enable |
| ln_valid | input | 4 | Per-line character offered |
| ln_char | input | 32 | Per-line character, line n in bits 8n+7:8n |
| ln_perr | input | 4 | Per-line parity error flag |
| ln_ferr | input | 4 | Per-line break (framing error) flag |
| ln_ack | output | 4 | Per-line acknowledge, the character is taken at this edge |
| rd_pop | input | 1 | Removes the oldest entry at this edge |
| rd_word | output | 16 | Oldest entry in read-word format, or 0 when empty |
| rx_done | output | 1 | At least one entry is waiting |
| rx_irq | output | 1 | Receive interrupt |
| ovr_pend | output | 1 | A character was lost and the mark is not yet written |

## Verification
`ln_ack` is combinational, so it is sampled one time step after the inputs change at the falling edge, before the rising edge that stores the character. A stored or popped entry changes `rd_word`, `rx_done` and `ovr_pend` at the next rising edge. The bench therefore checks them at the following falling edge, one cycle after the stimulus. Each operation is allowed exactly that one cycle, and no check waits for an event.

// File: rtl/rsilo_pkg.sv
// Package: shared widths and the stored-entry layout of the receive silo.
// Assumes the read word is a fixed 16 bits with an 8-bit character field.
package rsilo_pkg;
    localparam int CHAR_W = 8;
    localparam int TAG_W  = 2;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [TAG_W-1:0]  line;
        logic [CHAR_W-1:0] ch;
    } rsilo_entry_t;

    localparam int ENTRY_W = $bits(rsilo_entry_t);
endpackage

// File: rtl/rsilo_pick.sv
// Module: fixed-priority line picker. Grants the lowest-numbered requesting
// line while enabled and reports its index. Assumes NLINES >= 1.
module rsilo_pick #(
    parameter int NLINES = 4,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [NLINES-1:0] req,
    input  logic              en,
    output logic [NLINES-1:0] gnt,
    output logic [LW-1:0]     idx,
    output logic              any
);
    logic [NLINES:0] below;

    assign below[0] = 1'b0;

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            // Grant a line when no lower line requests.
            assign below[g+1] = below[g] | req[g];
            assign gnt[g]     = en & req[g] & ~below[g];
        end
    endgenerate

    assign any = en & below[NLINES];

    // Encode the granted line number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (gnt[i]) idx = LW'(i);
        end
    end
endmodule

// File: rtl/rsilo_store.sv
// Module: circular entry store with head read-out. Writes are ignored when
// full and pops are ignored when empty. Assumes DEPTH is a power of two.
module rsilo_store #(
    parameter int DEPTH = 64,
    parameter int EW    = 13,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_data,
    input  logic          rd_en,
    output logic [EW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_wr, do_rd;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign do_wr = wr_en & ~full;
    assign do_rd = rd_en & ~empty;
    assign head  = mem[rd_ptr];

    // Store the incoming entry at the tail.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rsilo_fmt.sv
// Module: builds the 16-bit host read word from the head entry. An absent
// entry reads as all zero.
module rsilo_fmt
    import rsilo_pkg::*;
(
    input  rsilo_entry_t      ent,
    input  logic              present,
    output logic [WORD_W-1:0] word
);
    // Place the fields and gate them with presence.
    always_comb begin
        word = '0;
        if (present) begin
            word[7:0]   = ent.ch;
            word[9:8]   = ent.line;
            word[11:10] = 2'b00;
            word[12]    = ent.perr;
            word[13]    = ent.ferr;
            word[14]    = ent.ovr;
            word[15]    = 1'b1;
        end
    end
endmodule

// File: rtl/rx_silo.sv
// Module: multi-line receive silo top. Takes one character per cycle from
// NLINES receivers by fixed priority, tags it and queues it in a DEPTH
// entry store, and shows the oldest entry to the host. Assumes NLINES <= 4
// so the line number fits the 2-bit tag field.
module rx_silo
    import rsilo_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int DEPTH  = 64,
    localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     scan_en,
    input  logic                     rx_int_en,
    input  logic [NLINES-1:0]        ln_valid,
    input  logic [NLINES*CHAR_W-1:0] ln_char,
    input  logic [NLINES-1:0]        ln_perr,
    input  logic [NLINES-1:0]        ln_ferr,
    output logic [NLINES-1:0]        ln_ack,
    input  logic                     rd_pop,
    output logic [WORD_W-1:0]        rd_word,
    output logic                     rx_done,
    output logic                     rx_irq,
    output logic                     ovr_pend
);
    logic         take_en;
    logic         any;
    logic [LW-1:0] idx;
    logic         full, empty;
    logic         wr_en, drop;
    rsilo_entry_t new_ent, head_ent;

    assign take_en = scan_en & ~clr;

    rsilo_pick #(.NLINES(NLINES)) u_pick (
        .req (ln_valid),
        .en  (take_en),
        .gnt (ln_ack),
        .idx (idx),
        .any (any)
    );

    // Assemble the entry of the granted line.
    always_comb begin
        new_ent.ch   = ln_char[idx*CHAR_W +: CHAR_W];
        new_ent.line = TAG_W'(idx);
        new_ent.perr = ln_perr[idx];
        new_ent.ferr = ln_ferr[idx];
        new_ent.ovr  = ovr_pend;
    end

    assign wr_en = any & ~full;
    assign drop  = any & full;

    // Remember a lost character until the next entry carries the mark.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  ovr_pend <= 1'b0;
        else if (drop)      ovr_pend <= 1'b1;
        else if (wr_en)     ovr_pend <= 1'b0;
    end

    rsilo_store #(.DEPTH(DEPTH), .EW(ENTRY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr),
        .wr_en   (wr_en),
        .wr_data (new_ent),
        .rd_en   (rd_pop & ~clr),
        .head    (head_ent),
        .empty   (empty),
        .full    (full)
    );

    rsilo_fmt u_fmt (
        .ent     (head_ent),
        .present (~empty),
        .word    (rd_word)
    );

    assign rx_done = ~empty;
    assign rx_irq  = rx_done & rx_int_en;
endmodule

// File: rtl/rx_silo_chk.sv
// Module: property checker for rx_silo, bound to every instance.
// Assumes synchronous active-low reset.
module rx_silo_chk #(
    parameter int NLINES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              scan_en,
    input logic              rx_int_en,
    input logic [NLINES-1:0] ln_valid,
    input logic [NLINES-1:0] ln_ack,
    input logic [15:0]       rd_word,
    input logic              rx_done,
    input logic              rx_irq,
    input logic              ovr_pend
);
    AST_ACK_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ln_ack)); // R7
    AST_ACK_LOWEST:  assert property (@(posedge clk) disable iff (!rst_n) (ln_valid[0] && scan_en && !clr) |-> ln_ack[0]); // R7
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (ln_ack & ~ln_valid) == '0); // R7
    AST_GATED_OFF:   assert property (@(posedge clk) disable iff (!rst_n) (!scan_en || clr) |-> (ln_ack == '0)); // R6
    AST_EMPTY_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) !rx_done |-> (rd_word == 16'h0000)); // R3
    AST_VALID_BIT:   assert property (@(posedge clk) disable iff (!rst_n) rx_done |-> (rd_word[15] && rd_word[11:10] == 2'b00)); // R2
    AST_IRQ_ENABLE:  assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> (rx_done && rx_int_en)); // R5
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (!rx_done && !ovr_pend)); // R10
    AST_OVR_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_pend) |-> $past(ln_ack != '0)); // R9
endmodule

bind rx_silo rx_silo_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .scan_en   (scan_en),
    .rx_int_en (rx_int_en),
    .ln_valid  (ln_valid),
    .ln_ack    (ln_ack),
    .rd_word   (rd_word),
    .rx_done   (rx_done),
    .rx_irq    (rx_irq),
    .ovr_pend  (ovr_pend)
);

// File: tb/rx_silo_test.sv
module rx_silo_test;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n, clr, scan_en, rx_int_en, rd_pop;
    logic [3:0]  ln_valid, ln_perr, ln_ferr, ln_ack;
    logic [31:0] ln_char;
    logic [15:0] rd_word;
    logic        rx_done, rx_irq, ovr_pend;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Vector fields: [11] break, [10] parity, [9:8] line, [7:0] character.
    localparam logic [11:0] VEC [6] = '{12'h041, 12'h1F0, 12'h67E, 12'hB00, 12'hF55, 12'h1A5};

    rx_silo uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .scan_en(scan_en), .rx_int_en(rx_int_en),
        .ln_valid(ln_valid), .ln_char(ln_char), .ln_perr(ln_perr), .ln_ferr(ln_ferr),
        .ln_ack(ln_ack), .rd_pop(rd_pop), .rd_word(rd_word), .rx_done(rx_done),
        .rx_irq(rx_irq), .ovr_pend(ovr_pend)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] mk(input int ln, input logic [7:0] ch,
                                       input logic pe, input logic fe, input logic ov);
        return {1'b1, ov, fe, pe, 2'b00, 2'(ln), ch};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Offer one character on one line for one cycle; returns the acknowledge.
    task automatic push_one(input int ln, input logic [7:0] ch, input logic pe,
                            input logic fe, output logic ack);
        @(negedge clk);
        ln_valid[ln] = 1'b1;
        ln_char[ln*8 +: 8] = ch;
        ln_perr[ln] = pe;
        ln_ferr[ln] = fe;
        #1 ack = ln_ack[ln];
        @(negedge clk);
        ln_valid = '0; ln_perr = '0; ln_ferr = '0;
    endtask

    // Compare the head word, then pop it.
    task automatic pop_check(input string req, input logic [15:0] exp);
        @(negedge clk);
        chk(req, rd_word, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic fill_and_drop();
        logic a;
        for (int i = 0; i < 64; i++) push_one(1, 8'(i), 1'b0, 1'b0, a);
        push_one(1, 8'hAA, 1'b0, 1'b0, a);
        chk("R8 ack on full", 16'(a), 16'd1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        rst_n = 1'b0; clr = 1'b0; scan_en = 1'b1; rx_int_en = 1'b1; rd_pop = 1'b0;
        ln_valid = '0; ln_perr = '0; ln_ferr = '0; ln_char = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 word", rd_word, 16'h0);
        chk("R1 done", 16'(rx_done), 16'd0);
        chk("R1 irq", 16'(rx_irq), 16'd0);
        chk("R1 ovr", 16'(ovr_pend), 16'd0);

        // Table walk: store every vector, then read them back in order (R2, R4).
        for (int v = 0; v < 6; v++) begin
            push_one(int'(VEC[v][9:8]), VEC[v][7:0], VEC[v][10], VEC[v][11], a);
            chk("R7 single ack", 16'(a), 16'd1);
        end
        @(negedge clk);
        chk("R5 done", 16'(rx_done), 16'd1);
        chk("R5 irq on", 16'(rx_irq), 16'd1);
        rx_int_en = 1'b0;
        #1 chk("R5 irq off", 16'(rx_irq), 16'd0);
        rx_int_en = 1'b1;
        for (int v = 0; v < 6; v++)
            pop_check("R2 R4 table", mk(int'(VEC[v][9:8]), VEC[v][7:0], VEC[v][10], VEC[v][11], 1'b0));

        // R3 empty read and pop on empty
        @(negedge clk);
        chk("R3 empty word", rd_word, 16'h0);
        chk("R5 done empty", 16'(rx_done), 16'd0);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        push_one(2, 8'h3C, 1'b0, 1'b0, a);
        pop_check("R3 pop empty ignored", mk(2, 8'h3C, 1'b0, 1'b0, 1'b0));

        // R6 scan enable gating
        scan_en = 1'b0;
        push_one(0, 8'h99, 1'b0, 1'b0, a);
        chk("R6 no ack", 16'(a), 16'd0);
        chk("R6 nothing stored", rd_word, 16'h0);
        scan_en = 1'b1;

        // R7 simultaneous lines, one per cycle, lowest first
        @(negedge clk);
        ln_valid = 4'hF;
        for (int i = 0; i < NL; i++) ln_char[i*8 +: 8] = 8'(8'h10 + i);
        for (int k = 0; k < NL; k++) begin
            #1 chk("R7 priority ack", 16'(ln_ack), 16'(1 << k));
            @(negedge clk);
            ln_valid[k] = 1'b0;
        end
        for (int k = 0; k < NL; k++)
            pop_check("R7 order", mk(k, 8'(8'h10 + k), 1'b0, 1'b0, 1'b0));

        // R8 / R9 depth limit and overrun marking
        fill_and_drop();
        @(negedge clk);
        chk("R9 pending", 16'(ovr_pend), 16'd1);
        for (int i = 0; i < 64; i++)
            pop_check("R8 stored", mk(1, 8'(i), 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        chk("R8 dropped not stored", rd_word, 16'h0);
        push_one(2, 8'h11, 1'b0, 1'b0, a);
        chk("R9 pending cleared", 16'(ovr_pend), 16'd0);
        push_one(3, 8'h22, 1'b1, 1'b0, a);
        pop_check("R9 marked", mk(2, 8'h11, 1'b0, 1'b0, 1'b1));
        pop_check("R9 unmarked", mk(3, 8'h22, 1'b1, 1'b0, 1'b0));

        // R10 master clear drops entries and pending overrun
        fill_and_drop();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R10 R1 word", rd_word, 16'h0);
        chk("R10 R1 done", 16'(rx_done), 16'd0);
        chk("R10 R1 ovr", 16'(ovr_pend), 16'd0);
        push_one(0, 8'h5A, 1'b0, 1'b1, a);
        pop_check("R10 no mark", mk(0, 8'h5A, 1'b0, 1'b1, 1'b0));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule